// File: doc/BRIEF.md
# GPIO Port Protected Configuration Bank

This block is the configuration store of one GPIO port. It holds the per-pin alternate-function selection and a set of pad-control words: three drive-strength selections, open drain, pull-up, pull-down, slew control, digital enable and analog selection. It drives each stored word straight out to the pad ring. Software reaches it over a simple single-cycle register bus inside a 4 KB window. The top of that window returns twelve read-only identification bytes, which are set by a module parameter.

The alternate-function word is protected. A write to it changes only the pins whose bit is set in a commit mask. The commit mask can be rewritten only after a 32-bit key has been written to the lock register. Writing any other value to the lock register locks the bank again. An access to the reserved part of the window reads as zero, changes nothing, and pulses an error flag. Offsets that belong to the port's other logic (data, direction and interrupt registers) are not decoded here. They read as zero and raise no error.

Top module: `gpio_cfg_bank`

## Requirements
- R1: Writing 0x0ACCE551 to the lock register (offset 0x520) unlocks the bank, and writing any other 32-bit value locks it. A read of 0x520 returns 1 while the bank is locked and 0 while it is unlocked.
- R2: After a synchronous reset the bank is locked. The commit mask (0x524) reads 0xFF and the 2 mA drive word (0x500) reads 0xFF. The alternate-function word and every other pad word read 0.
- R3: A write to the commit register (offset 0x524) stores bits 7:0 of the write data only while the bank is unlocked. While the bank is locked the write has no effect.
- R4: A write to the alternate-function register (offset 0x420) changes exactly those bits whose commit-mask bit is 1. All other bits keep their value.
- R5: The pad words sit at these offsets: 0x500 drive 2 mA, 0x504 drive 4 mA, 0x508 drive 8 mA, 0x50C open drain, 0x510 pull-up, 0x514 pull-down, 0x518 slew, 0x51C digital enable, 0x528 analog select. Each word stores bits 7:0 of the write data, reads back zero-extended, and drives its own output port.
- R6: Read data is registered and is valid in the cycle after the read access. In every cycle that does not follow a read, the read data is 0.
- R7: Offsets 0x52C to 0xFCF are reserved. A read there returns 0 and a write there changes nothing. Either access sets `bus_err` for exactly the one cycle after the access.
- R8: Offsets 0xFD0 to 0xFFC return identification byte (offset − 0xFD0) >> 2, zero-extended. A write there is ignored and raises `bus_err` as in R7.
- R9: Offsets outside this bank's registers and outside the reserved and identification ranges (for example 0x400 and 0x424) read as 0, ignore writes, and raise no error.
- R10: No register changes while `bus_en` is low, whatever the other bus inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a reserved or read-only-violating access |
| altfn_o | output | W | Alternate-function selection per pin |
| drive2_o | output | W | 2 mA drive selection |
| drive4_o | output | W | 4 mA drive selection |
| drive8_o | output | W | 8 mA drive selection |
| odrain_o | output | W | Open-drain enable |
| pullup_o | output | W | Pull-up enable |
| pulldn_o | output | W | Pull-down enable |
| slew_o | output | W | Slew-rate control |
| digen_o | output | W | Digital enable |
| analog_o | output | W | Analog selection |

## Verification
Every result of an access is due one clock edge after the edge that samples the access. The read word, the error pulse and the new register value that a write drives onto a pad port all appear together at that edge. The bench drives each access on a falling edge and samples `bus_rdata` and `bus_err` on the next falling edge, which falls half a period after the result edge. Register contents are observed by a later read or on the pad ports, which are both stable by then. The idle and reset checks sample the ports on falling edges only, after the edge under test has passed.

// File: rtl/gpio_cfg_pkg.sv
// Shared constants and types of the GPIO configuration bank.
// Assumes a 4 KB window addressed by a 12-bit byte offset.
package gpio_cfg_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int NUM_PAD = 9;
    localparam int NUM_ID  = 12;
    localparam int PIDX_W  = $clog2(NUM_PAD);
    localparam int IIDX_W  = $clog2(NUM_ID);

    localparam logic [ADDR_W-1:0] OFF_ALTFN   = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_PAD_LO  = 12'h500;
    localparam logic [ADDR_W-1:0] OFF_LOCK    = 12'h520;
    localparam logic [ADDR_W-1:0] OFF_COMMIT  = 12'h524;
    localparam logic [ADDR_W-1:0] OFF_ANALOG  = 12'h528;
    localparam logic [ADDR_W-1:0] OFF_RSV_LO  = 12'h52C;
    localparam logic [ADDR_W-1:0] OFF_ID_LO   = 12'hFD0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALTFN,
        SEL_PAD,
        SEL_LOCK,
        SEL_COMMIT,
        SEL_ID,
        SEL_RSVD
    } sel_e;
endpackage

// File: rtl/gpio_cfg_decode.sv
// Address decoder: classifies a bus offset into a register group and
// yields the pad-word index and identification-byte index.
// Assumes pad words are word aligned; unaligned offsets fall to SEL_NONE
// unless they lie in the reserved or identification range.
module gpio_cfg_decode
    import gpio_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [PIDX_W-1:0] pad_idx,
    output logic [IIDX_W-1:0] id_idx
);
    // Group selection and pad index from the offset
    always_comb begin
        sel     = SEL_NONE;
        pad_idx = '0;
        if (addr >= OFF_ID_LO) begin
            sel = SEL_ID;
        end else if (addr >= OFF_RSV_LO) begin
            sel = SEL_RSVD;
        end else if (addr == OFF_ALTFN) begin
            sel = SEL_ALTFN;
        end else if (addr == OFF_LOCK) begin
            sel = SEL_LOCK;
        end else if (addr == OFF_COMMIT) begin
            sel = SEL_COMMIT;
        end else if (addr == OFF_ANALOG) begin
            sel     = SEL_PAD;
            pad_idx = PIDX_W'(NUM_PAD - 1);
        end else if (addr >= OFF_PAD_LO && addr < OFF_LOCK && addr[1:0] == 2'b00) begin
            sel     = SEL_PAD;
            pad_idx = PIDX_W'((addr - OFF_PAD_LO) >> 2);
        end
    end

    // Identification byte index, one byte per word
    assign id_idx = IIDX_W'((addr - OFF_ID_LO) >> 2);
endmodule

// File: rtl/gpio_cfg_guard.sv
// Key lock, commit mask and the commit-masked alternate-function word.
// Assumes at most one write strobe is high per cycle.
module gpio_cfg_guard
    import gpio_cfg_pkg::*;
#(
    parameter int                W   = 8,
    parameter logic [DATA_W-1:0] KEY = 32'h0ACC_E551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic              commit_wr,
    input  logic              altfn_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked,
    output logic [W-1:0]      commit,
    output logic [W-1:0]      altfn
);
    // Lock state: only the exact key clears it
    always_ff @(posedge clk) begin
        if (!rst_n)       locked <= 1'b1;
        else if (lock_wr) locked <= (wdata != KEY);
    end

    // Commit mask: writable only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n)                     commit <= '1;
        else if (commit_wr && !locked)  commit <= wdata[W-1:0];
    end

    // Alternate-function word: per-bit update under the commit mask
    always_ff @(posedge clk) begin
        if (!rst_n)        altfn <= '0;
        else if (altfn_wr) altfn <= (altfn & ~commit) | (wdata[W-1:0] & commit);
    end
endmodule

// File: rtl/gpio_cfg_padfile.sv
// Pad-control register file: NUM_PAD words of W bits, word 0 resets to
// all ones and the rest to zero. Assumes idx < NUM_PAD when wr is high.
module gpio_cfg_padfile
    import gpio_cfg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [PIDX_W-1:0]          idx,
    input  logic [W-1:0]               wdata,
    output logic [NUM_PAD-1:0][W-1:0]  words
);
    for (genvar i = 0; i < NUM_PAD; i++) begin : g_word
        localparam logic [W-1:0] RST_VAL = (i == 0) ? {W{1'b1}} : {W{1'b0}};
        // One pad word, loaded when its index is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)                          words[i] <= RST_VAL;
            else if (wr && idx == PIDX_W'(i))    words[i] <= wdata;
        end
    end
endmodule

// File: rtl/gpio_cfg_bank.sv
// Top of the GPIO configuration bank: decodes the register bus, routes
// writes to the guarded and pad registers, returns registered read data
// and flags reserved or read-only-violating accesses one cycle later.
// Assumes single-cycle accesses with no back-pressure.
module gpio_cfg_bank
    import gpio_cfg_pkg::*;
#(
    parameter int                        W        = 8,
    parameter logic [DATA_W-1:0]         KEY      = 32'h0ACC_E551,
    parameter logic [NUM_ID-1:0][7:0]    ID_BYTES = 96'hB105F00D_00081047_00000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [W-1:0]      altfn_o,
    output logic [W-1:0]      drive2_o,
    output logic [W-1:0]      drive4_o,
    output logic [W-1:0]      drive8_o,
    output logic [W-1:0]      odrain_o,
    output logic [W-1:0]      pullup_o,
    output logic [W-1:0]      pulldn_o,
    output logic [W-1:0]      slew_o,
    output logic [W-1:0]      digen_o,
    output logic [W-1:0]      analog_o
);
    sel_e                      sel;
    logic [PIDX_W-1:0]         pad_idx;
    logic [IIDX_W-1:0]         id_idx;
    logic                      wr_cyc;
    logic                      rd_cyc;
    logic                      lock_q;
    logic [W-1:0]              commit_q;
    logic [NUM_PAD-1:0][W-1:0] pads;

    assign wr_cyc = bus_en &&  bus_wr;
    assign rd_cyc = bus_en && !bus_wr;

    gpio_cfg_decode u_dec (
        .addr    (bus_addr),
        .sel     (sel),
        .pad_idx (pad_idx),
        .id_idx  (id_idx)
    );

    gpio_cfg_guard #(.W(W), .KEY(KEY)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_wr   (wr_cyc && sel == SEL_LOCK),
        .commit_wr (wr_cyc && sel == SEL_COMMIT),
        .altfn_wr  (wr_cyc && sel == SEL_ALTFN),
        .wdata     (bus_wdata),
        .locked    (lock_q),
        .commit    (commit_q),
        .altfn     (altfn_o)
    );

    gpio_cfg_padfile #(.W(W)) u_pads (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_cyc && sel == SEL_PAD),
        .idx   (pad_idx),
        .wdata (bus_wdata[W-1:0]),
        .words (pads)
    );

    assign drive2_o = pads[0];
    assign drive4_o = pads[1];
    assign drive8_o = pads[2];
    assign odrain_o = pads[3];
    assign pullup_o = pads[4];
    assign pulldn_o = pads[5];
    assign slew_o   = pads[6];
    assign digen_o  = pads[7];
    assign analog_o = pads[8];

    // Registered read mux; zero outside read cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_cyc) begin
            bus_rdata <= '0;
        end else begin
            case (sel)
                SEL_ALTFN:  bus_rdata <= DATA_W'(altfn_o);
                SEL_PAD:    bus_rdata <= DATA_W'(pads[pad_idx]);
                SEL_LOCK:   bus_rdata <= DATA_W'(lock_q);
                SEL_COMMIT: bus_rdata <= DATA_W'(commit_q);
                SEL_ID:     bus_rdata <= DATA_W'(ID_BYTES[id_idx]);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // Error pulse for reserved accesses and writes to the identification bytes
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= bus_en && (sel == SEL_RSVD || (sel == SEL_ID && bus_wr));
    end
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
// Property checker for gpio_cfg_bank, attached by bind.
module gpio_cfg_bank_chk
    import gpio_cfg_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              lock_q,
    input logic [W-1:0]      commit_q,
    input logic [W-1:0]      altfn_o,
    input logic [9*W-1:0]    pad_bus
);
    logic in_rsvd;
    assign in_rsvd = bus_addr >= 12'h52C && bus_addr < 12'hFD0;

    // R1
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == 12'h520 && bus_wdata == 32'h0ACC_E551) |=> !lock_q);
    // R1
    bad_key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == 12'h520 && bus_wdata != 32'h0ACC_E551) |=> lock_q);
    // R3
    commit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == 12'h524 && lock_q) |=> $stable(commit_q));
    // R4
    altfn_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((altfn_o ^ $past(altfn_o)) & ~$past(commit_q)) == '0);
    // R7
    rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && in_rsvd) |=> bus_err);
    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && in_rsvd) |=> bus_rdata == '0);
    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_wr) |=> bus_rdata == '0);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> ($stable(pad_bus) && $stable(altfn_o) && $stable(commit_q) && $stable(lock_q)));
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .lock_q    (lock_q),
    .commit_q  (commit_q),
    .altfn_o   (altfn_o),
    .pad_bus   (pads)
);

// File: tb/gpio_cfg_bank_tb_top.sv
module gpio_cfg_bank_tb_top;
    localparam int VW = 82;
    localparam int NV = 36;

    function automatic logic [VW-1:0] mk(input logic wr, input logic [11:0] a,
                                         input logic [31:0] d, input logic [31:0] e,
                                         input logic er, input logic [3:0] rq);
        return {rq, wr, a, d, e, er};
    endfunction

    // Vector table: {requirement, write, offset, wdata, expected rdata, expected err}
    localparam logic [VW-1:0] VECS [NV] = '{
        mk(0, 12'h520, 0, 32'h1, 0, 2),          // R2 locked after reset
        mk(0, 12'h524, 0, 32'hFF, 0, 2),         // R2 commit mask all ones
        mk(0, 12'h500, 0, 32'hFF, 0, 2),         // R2 drive 2 mA all ones
        mk(0, 12'h51C, 0, 32'h0, 0, 2),          // R2
        mk(0, 12'h420, 0, 32'h0, 0, 2),          // R2
        mk(1, 12'h524, 32'h0, 0, 0, 3),          // R3 locked: ignored
        mk(0, 12'h524, 0, 32'hFF, 0, 3),         // R3
        mk(1, 12'h420, 32'hA5, 0, 0, 4),         // R4 full mask
        mk(0, 12'h420, 0, 32'hA5, 0, 4),         // R4
        mk(1, 12'h520, 32'h0ACCE551, 0, 0, 1),   // R1 key
        mk(0, 12'h520, 0, 32'h0, 0, 1),          // R1 unlocked
        mk(1, 12'h524, 32'hFFFFFF0F, 0, 0, 3),   // R3 low byte only
        mk(0, 12'h524, 0, 32'h0F, 0, 3),         // R3
        mk(1, 12'h420, 32'h5A, 0, 0, 4),         // R4 partial mask
        mk(0, 12'h420, 0, 32'hAA, 0, 4),         // R4 (A5&F0)|(5A&0F)
        mk(1, 12'h520, 32'h0ACCE550, 0, 0, 1),   // R1 near-miss relocks
        mk(0, 12'h520, 0, 32'h1, 0, 1),          // R1
        mk(1, 12'h524, 32'h33, 0, 0, 3),         // R3 relocked: ignored
        mk(0, 12'h524, 0, 32'h0F, 0, 3),         // R3
        mk(1, 12'h528, 32'h3C, 0, 0, 5),         // R5 analog
        mk(0, 12'h528, 0, 32'h3C, 0, 5),         // R5
        mk(1, 12'h50C, 32'h81, 0, 0, 5),         // R5 open drain
        mk(0, 12'h50C, 0, 32'h81, 0, 5),         // R5
        mk(1, 12'h504, 32'h1FF, 0, 0, 5),        // R5 8 bits kept
        mk(0, 12'h504, 0, 32'hFF, 0, 5),         // R5
        mk(0, 12'h600, 0, 32'h0, 1, 7),          // R7 reserved read
        mk(1, 12'h600, 32'hFF, 0, 1, 7),         // R7 reserved write
        mk(0, 12'h52C, 0, 32'h0, 1, 7),          // R7 lower bound
        mk(0, 12'hFCC, 0, 32'h0, 1, 7),          // R7 upper bound
        mk(0, 12'hFE0, 0, 32'h47, 0, 8),         // R8 byte 4
        mk(0, 12'hFFC, 0, 32'hB1, 0, 8),         // R8 byte 11
        mk(1, 12'hFE0, 32'hFF, 0, 1, 8),         // R8 write flagged
        mk(0, 12'hFE0, 0, 32'h47, 0, 8),         // R8 unchanged
        mk(0, 12'h400, 0, 32'h0, 0, 9),          // R9 foreign offset
        mk(1, 12'h424, 32'hFF, 0, 0, 9),         // R9 foreign write
        mk(0, 12'h528, 0, 32'h3C, 0, 9)          // R9 nothing changed
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  altfn_o, drive2_o, drive4_o, drive8_o, odrain_o;
    logic [7:0]  pullup_o, pulldn_o, slew_o, digen_o, analog_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_cfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .altfn_o(altfn_o), .drive2_o(drive2_o),
        .drive4_o(drive4_o), .drive8_o(drive8_o), .odrain_o(odrain_o),
        .pullup_o(pullup_o), .pulldn_o(pulldn_o), .slew_o(slew_o),
        .digen_o(digen_o), .analog_o(analog_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access driven after a falling edge, results sampled at the next one
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state on ports
        check("R2 altfn", 32'(altfn_o), 0);
        check("R2 drive2", 32'(drive2_o), 32'hFF);
        check("R2 others", 32'({drive4_o, drive8_o, odrain_o, pullup_o, pulldn_o, slew_o, digen_o, analog_o}), 0);
        check("R6 idle rdata", bus_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VECS[i];
            access(v[77], v[76:65], v[64:33], rd, er);
            check($sformatf("R%0d vec%0d rdata", v[81:78], i), rd, v[32:1]);
            check($sformatf("R%0d vec%0d err", v[81:78], i), 32'(er), 32'(v[0]));
        end

        // R5 pad and R4 alternate-function values on ports
        check("R4 altfn port", 32'(altfn_o), 32'hAA);
        check("R5 analog port", 32'(analog_o), 32'h3C);
        check("R5 odrain port", 32'(odrain_o), 32'h81);
        check("R5 drive4 port", 32'(drive4_o), 32'hFF);
        check("R7 err one cycle", 32'(bus_err), 0);

        // R10 strobe low: write-looking inputs have no effect
        bus_en = 1'b0; bus_wr = 1'b1; bus_addr = 12'h528; bus_wdata = 32'h0;
        @(negedge clk);
        check("R10 analog held", 32'(analog_o), 32'h3C);
        bus_addr = 12'h420;
        @(negedge clk);
        check("R10 altfn held", 32'(altfn_o), 32'hAA);
        bus_wr = 1'b0;
        access(1'b0, 12'h528, 0, rd, er);
        check("R10 analog read", rd, 32'h3C);

        // R2 reset in mid-run restores defaults
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R2 rerst altfn", 32'(altfn_o), 0);
        check("R2 rerst analog", 32'(analog_o), 0);
        check("R2 rerst drive2", 32'(drive2_o), 32'hFF);
        access(1'b0, 12'h520, 0, rd, er);
        check("R2 rerst lock", rd, 1);
        access(1'b0, 12'h524, 0, rd, er);
        check("R2 rerst commit", rd, 32'hFF);

        finish_run();
    end
endmodule